// File: doc/BRIEF.md
# Scanline Block Descriptor Fetcher

This block drives the per-line set-up of a raster display from a table in memory. The screen is split into variable-height blocks. Each block has its own descriptor holding a video mode, a start address for its pixel data, a line stride and an eight-byte palette override. The block walks the table once per frame. When a block's first line comes up, the block reads that block's descriptor. For every visible scanline it then strobes out the mode, the byte address to fetch the line's pixels from, and the palette bytes in force.

A frame pulse reloads the table pointer from a programmable base and discards whatever remains of the current block. A line pulse, issued during horizontal blanking, asks for the next line's parameters. Lines beyond the frame's visible count are refused. The memory side has one read outstanding at a time. The request and its word-aligned address are held until the read data comes back with a valid pulse.

Top module: `vdl_line_fetch`

## Requirements
- R1: After reset, `line_valid_o` and `mem_req_o` are low.
- R2: A descriptor is four 32-bit words at increasing addresses. Word 0 holds the line count in bits [7:0], the mode byte in [15:8] and the line stride in [31:16]. Word 1 holds the start address. Words 2 and 3 hold palette bytes 0..3 and 4..7, least significant byte first. Palette byte k appears on `pal_o[8k+7:8k]`.
- R3: On the first line of a block, the block reads the descriptor's four words in order at pointer +0, +4, +8 and +12, one at a time. Each address is held until `mem_rvalid_i`. The line strobe then carries the start address, mode and palette.
- R4: Each later line of a block strobes `line_valid_o` for exactly one cycle, in the cycle after the line pulse is taken, with no memory read. Its address is the previous line's address plus the stride.
- R5: A line count of 0 means a block of 256 lines.
- R6: Only the low four bits of the mode byte reach `mode_o`. The upper four bits are ignored.
- R7: A frame pulse loads the table pointer from `table_base_i`. The frame's first line reads its descriptor from that base.
- R8: Once `visible_lines_i` lines have been strobed in a frame, further line pulses cause neither a strobe nor a memory read.
- R9: A frame pulse arriving mid-block drops the remaining lines of that block. The next line fetches a fresh descriptor from the base.
- R10: When a block is used up, the next line reads the following descriptor at the previous descriptor's address plus 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| table_base_i | input | 32 | Byte address of the first descriptor |
| visible_lines_i | input | LINE_W | Visible lines per frame |
| frame_start_i | input | 1 | Start-of-frame pulse |
| line_start_i | input | 1 | Request for the next line's parameters |
| mem_req_o | output | 1 | Read request, held until data returns |
| mem_addr_o | output | 32 | Word-aligned read byte address |
| mem_rvalid_i | input | 1 | Read data valid, completes the request |
| mem_rdata_i | input | 32 | Read data |
| line_valid_o | output | 1 | One-cycle strobe: line parameters valid |
| mode_o | output | 4 | Video mode of the line |
| line_addr_o | output | 32 | Byte address of the line's pixel data |
| pal_o | output | 64 | Palette override bytes |

## Verification
The hardest case to reach is the full 256-line block given by a zero count. Its last line has to be followed by a read of the next descriptor, and that happens only after 256 accepted line pulses in a frame whose visible count is larger than 256. The stimulus points the table base straight at a zero-count descriptor and sets 300 visible lines. It steps every line, checking each stride-advanced address, up to the 257th pulse, where the next descriptor's read and its contents are checked. Truncation is reached by ending a frame in the middle of that same long block.

// File: rtl/vdl_pkg.sv
package vdl_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned PAL_N    = 8;
  localparam int unsigned DESC_WDS = 4;
  localparam int unsigned DESC_B   = DESC_WDS * 4;

  typedef struct packed {
    logic [15:0]          stride;
    logic [7:0]           mode;
    logic [7:0]           count;
    logic [ADDR_W-1:0]    start;
    logic [PAL_N*8-1:0]   pal;
  } vdl_desc_t;
endpackage

// File: rtl/vdl_desc_fetch.sv
module vdl_desc_fetch
  import vdl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output vdl_desc_t         desc_o
);
  localparam int unsigned IDX_W = $clog2(DESC_WDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DESC_WDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      word_q [DESC_WDS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && mem_rvalid_i) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  // words before the last are parked; the last is used straight off the bus
  generate
    for (genvar g = 0; g < DESC_WDS - 1; g++) begin : g_word
      always_ff @(posedge clk_i) begin
        if (busy_q && mem_rvalid_i && idx_q == IDX_W'(g)) word_q[g] <= mem_rdata_i;
      end
    end
  endgenerate

  assign mem_req_o  = busy_q;
  assign mem_addr_o = ptr_i + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign done_o     = busy_q && mem_rvalid_i && (idx_q == LAST) && !abort_i;

  assign desc_o.count  = word_q[0][7:0];
  assign desc_o.mode   = word_q[0][15:8];
  assign desc_o.stride = word_q[0][31:16];
  assign desc_o.start  = word_q[1];
  assign desc_o.pal    = {mem_rdata_i, word_q[2]};
endmodule

// File: rtl/vdl_line_walker.sv
module vdl_line_walker
  import vdl_pkg::*;
#(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] visible_i,
  input  logic [ADDR_W-1:0] table_base_i,
  input  logic              fetch_done_i,
  input  vdl_desc_t         desc_i,
  output logic              fetch_start_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              line_valid_o,
  output logic [3:0]        mode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [PAL_N*8-1:0] pal_o
);
  localparam int unsigned REM_W = 9;

  logic [REM_W-1:0]  remain_q;
  logic [LINE_W-1:0] done_q;
  logic              wait_q;
  logic [ADDR_W-1:0] cur_q;
  logic [15:0]       stride_q;
  logic              accept;
  logic [REM_W-1:0]  count_ext;

  assign accept        = line_start_i && !frame_start_i && !wait_q && (done_q < visible_i);
  assign fetch_start_o = accept && (remain_q == '0);
  assign count_ext     = (desc_i.count == 8'd0) ? REM_W'(256) : {1'b0, desc_i.count};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o        <= '0;
      remain_q     <= '0;
      done_q       <= '0;
      wait_q       <= 1'b0;
      cur_q        <= '0;
      stride_q     <= '0;
      line_valid_o <= 1'b0;
      mode_o       <= '0;
      addr_o       <= '0;
      pal_o        <= '0;
    end else begin
      line_valid_o <= 1'b0;
      if (frame_start_i) begin
        ptr_o    <= table_base_i;
        remain_q <= '0;
        done_q   <= '0;
        wait_q   <= 1'b0;
      end else begin
        if (accept) begin
          done_q <= done_q + 1'b1;
          if (remain_q == '0) begin
            wait_q <= 1'b1;
          end else begin
            line_valid_o <= 1'b1;
            addr_o       <= cur_q;
            cur_q        <= cur_q + {16'd0, stride_q};
            remain_q     <= remain_q - 1'b1;
          end
        end
        if (fetch_done_i) begin
          wait_q       <= 1'b0;
          line_valid_o <= 1'b1;
          addr_o       <= desc_i.start;
          mode_o       <= desc_i.mode[3:0];
          pal_o        <= desc_i.pal;
          stride_q     <= desc_i.stride;
          cur_q        <= desc_i.start + {16'd0, desc_i.stride};
          remain_q     <= count_ext - 1'b1;
          ptr_o        <= ptr_o + ADDR_W'(DESC_B);
        end
      end
    end
  end
endmodule

// File: rtl/vdl_line_fetch.sv
module vdl_line_fetch
  import vdl_pkg::*;
#(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       table_base_i,
  input  logic [LINE_W-1:0] visible_lines_i,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  output logic              mem_req_o,
  output logic [31:0]       mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              line_valid_o,
  output logic [3:0]        mode_o,
  output logic [31:0]       line_addr_o,
  output logic [63:0]       pal_o
);
  logic              fetch_start;
  logic              fetch_done;
  logic [ADDR_W-1:0] ptr;
  vdl_desc_t         desc;

  vdl_desc_fetch u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (fetch_start),
    .abort_i      (frame_start_i),
    .ptr_i        (ptr),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (fetch_done),
    .desc_o       (desc)
  );

  vdl_line_walker #(.LINE_W(LINE_W)) u_walk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_start_i  (line_start_i),
    .visible_i     (visible_lines_i),
    .table_base_i  (table_base_i),
    .fetch_done_i  (fetch_done),
    .desc_i        (desc),
    .fetch_start_o (fetch_start),
    .ptr_o         (ptr),
    .line_valid_o  (line_valid_o),
    .mode_o        (mode_o),
    .addr_o        (line_addr_o),
    .pal_o         (pal_o)
  );
endmodule

// File: rtl/vdl_line_fetch_chk.sv
module vdl_line_fetch_chk #(
  parameter int unsigned LINE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       table_base_i,
  input logic [LINE_W-1:0] visible_lines_i,
  input logic              frame_start_i,
  input logic              line_start_i,
  input logic              mem_req_o,
  input logic [31:0]       mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [31:0]       mem_rdata_i,
  input logic              line_valid_o,
  input logic [3:0]        mode_o,
  input logic [31:0]       line_addr_o,
  input logic [63:0]       pal_o
);
  logic [LINE_W:0] strobes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            strobes_q <= '0;
    else if (frame_start_i) strobes_q <= '0;
    else if (line_valid_o)  strobes_q <= strobes_q + 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i && !frame_start_i |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_ADDR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00); // R2
  AST_REQ_FROM_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(line_start_i)); // R3
  AST_NO_STROBE_MID_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> !mem_req_o); // R3
  AST_LINE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> strobes_q < {1'b0, visible_lines_i}); // R8
  AST_MODE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> line_valid_o); // R6
endmodule

bind vdl_line_fetch vdl_line_fetch_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_vdl_line_fetch.sv
module sim_vdl_line_fetch;
  localparam int LINE_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       table_base = '0;
  logic [LINE_W-1:0] visible = '0;
  logic              frame_start = 1'b0;
  logic              line_start = 1'b0;
  logic              mem_req;
  logic [31:0]       mem_addr;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = '0;
  logic              line_valid;
  logic [3:0]        mode;
  logic [31:0]       line_addr;
  logic [63:0]       pal;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int rd_cnt = 0;
  int vld_cnt = 0;
  int lat = 0;
  logic [31:0] mem [0:63];
  logic [31:0] rd_log [0:3];

  always #4 clk = ~clk;

  vdl_line_fetch #(.LINE_W(LINE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .table_base_i(table_base), .visible_lines_i(visible),
    .frame_start_i(frame_start), .line_start_i(line_start), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .line_valid_o(line_valid), .mode_o(mode), .line_addr_o(line_addr), .pal_o(pal)
  );

  // RAM model: answers a held request after two wait cycles
  always @(posedge clk) begin
    if (!mem_req) begin
      mem_rvalid <= 1'b0;
      lat <= 0;
    end else if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
      lat <= 0;
    end else if (lat == 2) begin
      mem_rvalid <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      rd_log[rd_cnt % 4] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
      lat <= 0;
    end else begin
      lat <= lat + 1;
    end
    if (line_valid) vld_cnt <= vld_cnt + 1;
    cycles <= cycles + 1;
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic new_frame(input logic [31:0] base, input int vis);
    table_base = base;
    visible = LINE_W'(vis);
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  // one line request; fetch=1 expects a descriptor read at table address ta
  task automatic run_line(input string r, input bit fetch, input logic [31:0] ta,
                          input logic [31:0] ea, input logic [3:0] em,
                          input bit cpal, input logic [63:0] ep);
    int rd0 = rd_cnt;
    int n = 0;
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
    if (fetch) begin
      while (!line_valid && n < 40) begin
        @(negedge clk);
        n++;
      end
    end
    chk({r, " strobe"}, 64'(line_valid), 64'd1);
    chk({r, " addr"}, 64'(line_addr), 64'(ea));
    chk({r, " mode"}, 64'(mode), 64'(em));
    if (cpal) chk({r, " pal"}, pal, ep);
    chk({r, " reads"}, 64'(rd_cnt - rd0), fetch ? 64'd4 : 64'd0);
    if (fetch) begin
      for (int k = 0; k < 4; k++) chk({r, " read order"}, 64'(rd_log[(rd0 + k) % 4]), 64'(ta + 32'(4 * k)));
    end
    @(negedge clk);
    chk({r, " one-cycle strobe R4"}, 64'(line_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(line_valid), 64'd0);
    chk("R1 req", 64'(mem_req), 64'd0);
  endtask

  task automatic t_two_blocks;
    new_frame(32'h0, 10);
    run_line("R2 R3 R6 first line", 1'b1, 32'h0, 32'h1000, 4'h5, 1'b1, 64'h0807060504030201);
    run_line("R4 line 1", 1'b0, 32'h0, 32'h1040, 4'h5, 1'b1, 64'h0807060504030201);
    run_line("R4 line 2", 1'b0, 32'h0, 32'h1080, 4'h5, 1'b0, '0);
    run_line("R10 next desc", 1'b1, 32'h10, 32'h2000_0000, 4'h3, 1'b1, 64'h1817161514131211);
    for (int i = 1; i < 7; i++)
      run_line("R4 block B", 1'b0, 32'h0, 32'h2000_0000 + 32'(16 * i), 4'h3, 1'b0, '0);
    begin
      int v0 = vld_cnt;
      int r0 = rd_cnt;
      @(negedge clk) line_start = 1'b1;
      @(negedge clk) line_start = 1'b0;
      repeat (10) @(negedge clk);
      chk("R8 no strobe past limit", 64'(vld_cnt - v0), 64'd0);
      chk("R8 no read past limit", 64'(rd_cnt - r0), 64'd0);
    end
  endtask

  task automatic t_truncate;
    new_frame(32'h0, 10);
    run_line("R9 restart at base", 1'b1, 32'h0, 32'h1000, 4'h5, 1'b0, '0);
    run_line("R9 second line", 1'b0, 32'h0, 32'h1040, 4'h5, 1'b0, '0);
  endtask

  task automatic t_long_block;
    new_frame(32'h10, 300);
    run_line("R5 first of 256", 1'b1, 32'h10, 32'h2000_0000, 4'h3, 1'b0, '0);
    for (int i = 1; i < 256; i++)
      run_line("R5 long block", 1'b0, 32'h0, 32'h2000_0000 + 32'(16 * i), 4'h3, 1'b0, '0);
    run_line("R5 R6 R10 after 256", 1'b1, 32'h20, 32'h4000, 4'hF, 1'b1, 64'h0);
  endtask

  task automatic t_new_base;
    new_frame(32'h80, 4);
    run_line("R7 base change", 1'b1, 32'h80, 32'h300, 4'h7, 1'b1, 64'h2827262524232221);
    run_line("R7 step", 1'b0, 32'h0, 32'h304, 4'h7, 1'b0, '0);
    run_line("R10 from new base", 1'b1, 32'h90, 32'h5000, 4'h1, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = 32'h0040A503; mem[1]  = 32'h0000_1000; mem[2]  = 32'h04030201; mem[3]  = 32'h08070605;
    mem[4]  = 32'h00100300; mem[5]  = 32'h2000_0000; mem[6]  = 32'h14131211; mem[7]  = 32'h18171615;
    mem[8]  = 32'h00003F01; mem[9]  = 32'h0000_4000;
    mem[32] = 32'h00040702; mem[33] = 32'h0000_0300; mem[34] = 32'h24232221; mem[35] = 32'h28272625;
    mem[36] = 32'h00010105; mem[37] = 32'h0000_5000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_two_blocks();
    t_truncate();
    t_long_block();
    t_new_base();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule